// File: doc/BRIEF.md
# CAN Transmit Buffer Request Tracker

This block tracks transmit requests for a CAN controller's set of transmit buffers. Software writes a mask to a request register. Each new bit becomes pending, and the block queues that buffer in arrival order. A small transmit engine removes queue entries one at a time. After a fixed latency it reports each buffer as sent. Frame encoding and the bus itself are outside this block. It keeps the sent-buffer register, the interrupt flags, a queue status word and a loopback receive-FIFO status word, and every completion is announced on a handoff port.

A request is never resolved in the cycle it is written. Software polling the pending register therefore always sees the bit set for several cycles. The queue status word reports free slots as the nominal queue depth minus the requests still in flight, and its put/get indices count completions modulo that depth.

Top module: `can_txreq_tracker`

## Requirements
- R1: Writing the request register (word address 0) sets the pending bit (word address 1) of every buffer whose bit is written as 1, readable on the next read. A request bit for a buffer that is already pending is ignored and produces no extra completion.
- R2: With the default LATENCY of 4, a single request written to an idle block produces its completion pulse on `done_valid` exactly LATENCY+2 clock cycles after the write is sampled, and never in the cycle of the write.
- R3: Completions occur in queue order: buffers written in separate cycles complete in the order written, and buffers written together complete in ascending buffer index.
- R4: A completion clears the buffer's pending bit and sets its bit in the sent register (word address 2). A new request for a buffer clears that buffer's sent bit.
- R5: Every completion sets interrupt flag bit 0 (queue empty). Interrupt flag bit 1 (transmit complete) is set only when the completing buffer's bit is 1 in the interrupt-enable register (word address 3). The flags are read at word address 5.
- R6: The interrupt register is write-one-to-clear: writing back the value just read clears all set flags. A flag set in the same cycle wins over the clear.
- R7: The queue status word (word address 4) holds the put index in bits 23:16, the get index in bits 15:8 and the free count in bits 7:0. Each completion advances the put index modulo QDEPTH (3), and the get index is then made equal to it. It reads 0x0001_0103 after one send from reset and 0x0002_0203 after two.
- R8: The free count equals QDEPTH minus the number of pending buffers, saturating at 0.
- R9: If a request for a buffer is written in the same cycle that the buffer completes, the pending bit stays set and the buffer is queued and completed a second time.
- R10: With control bit 0 (word address 8) set, each completion enters the receive FIFO. The receive status word (word address 6) has the put index at bit 16, the get index at bit 8 and the fill level in bits 6:0. A write to word address 7 pops one entry. A completion that arrives when the FIFO is full, or while control bit 0 is clear, leaves the receive status unchanged.
- R11: After reset the pending, sent and interrupt registers are 0, the queue status reads 0x0000_0003 and the receive status reads 0.
- R12: For each completion, `done_valid` pulses for one cycle and `done_buf` carries the completing buffer's index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 32 | Registered read data, one cycle after the address |
| done_valid | output | 1 | One-cycle pulse per completed buffer |
| done_buf | output | $clog2(NBUF) | Index of the completed buffer |

## Verification
The hardest case to reach is a request that coincides with a completion of the same buffer (R9). At that edge the pending bit is still set, so the write would normally be ignored. The bench computes the completion edge from LATENCY and times a second write to that buffer so that it is sampled on exactly that edge. It then checks that the pending bit survives and that two completions are logged. A further sweep covers every non-empty request mask against a varying interrupt-enable pattern, which checks completion order and the transmit-complete flag arithmetically.

// File: rtl/can_txreq_pkg.sv
package can_txreq_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_REQ    = 4'd0,
    RA_PEND   = 4'd1,
    RA_DONE   = 4'd2,
    RA_TIE    = 4'd3,
    RA_QSTAT  = 4'd4,
    RA_IRQ    = 4'd5,
    RA_RXSTAT = 4'd6,
    RA_RXACK  = 4'd7,
    RA_CTRL   = 4'd8
  } reg_addr_e;

  localparam int IRQ_FE = 0;
  localparam int IRQ_TC = 1;
  localparam int IRQ_W  = 2;

  function automatic logic [REG_W-1:0] pack_status(input logic [7:0] hi,
                                                   input logic [7:0] mid,
                                                   input logic [7:0] lo);
    return {8'h00, hi, mid, lo};
  endfunction
endpackage

// File: rtl/txreq_pick.sv
module txreq_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx
);
  logic found;
  always_comb begin
    grant = '0;
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        idx      = IW'(i);
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/txreq_queue.sv
module txreq_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage has no reset so it maps onto plain RAM
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  assign head  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/txreq_engine.sv
module txreq_engine #(
  parameter int LATENCY = 4,
  parameter int IW      = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          q_empty,
  input  logic [IW-1:0] q_head,
  output logic          pop,
  output logic          cmpl,
  output logic [IW-1:0] cur_idx
);
  localparam int CNT_W = $clog2(LATENCY + 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;

  assign cmpl = busy && (cnt == '0);
  assign pop  = (!busy || cmpl) && !q_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt     <= '0;
      cur_idx <= '0;
    end else if (pop) begin
      busy    <= 1'b1;
      cnt     <= CNT_W'(LATENCY - 1);
      cur_idx <= q_head;
    end else if (cmpl) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/can_txreq_tracker.sv
module can_txreq_tracker
  import can_txreq_pkg::*;
#(
  parameter int NBUF     = 4,
  parameter int QDEPTH   = 3,
  parameter int LATENCY  = 4,
  parameter int RX_DEPTH = 3,
  localparam int IW      = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              done_valid,
  output logic [IW-1:0]     done_buf
);
  localparam int QW  = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int RXW = (RX_DEPTH > 1) ? $clog2(RX_DEPTH) : 1;
  localparam int FW  = $clog2(RX_DEPTH + 1);
  localparam int PCW = $clog2(NBUF + 1);

  logic [NBUF-1:0]  pend_q, staged_q, done_q, tie_q;
  logic [NBUF-1:0]  acc, cmpl_mask, push_grant;
  logic [NBUF-1:0]  pend_n, staged_n, done_n;
  logic [IW-1:0]    push_idx, q_head, cur_idx;
  logic             q_push, q_pop, q_full, q_empty, cmpl;
  logic [IRQ_W-1:0] irq_q, irq_set, irq_clr;
  logic             loop_q;
  logic [QW-1:0]    qput_q, qget_q, qput_nx;
  logic [RXW-1:0]   rx_put_q, rx_get_q;
  logic [FW-1:0]    rx_fill_q;
  logic             rx_push, rx_pop;
  logic [PCW-1:0]   inflight;
  logic [7:0]       free_cnt;
  logic             wr_req, wr_tie, wr_irq, wr_ack, wr_ctrl;
  logic             done_valid_q;
  logic [IW-1:0]    done_buf_q;
  logic [REG_W-1:0] rd_q;

  assign wr_req  = wr_en && (wr_addr == RA_REQ);
  assign wr_tie  = wr_en && (wr_addr == RA_TIE);
  assign wr_irq  = wr_en && (wr_addr == RA_IRQ);
  assign wr_ack  = wr_en && (wr_addr == RA_RXACK);
  assign wr_ctrl = wr_en && (wr_addr == RA_CTRL);

  // per-buffer request, queue-staging and sent state
  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    assign cmpl_mask[b] = cmpl && (cur_idx == IW'(b));
    assign acc[b]       = wr_req && wr_data[b] && (!pend_q[b] || cmpl_mask[b]);
    assign pend_n[b]    = (pend_q[b] && !cmpl_mask[b]) || acc[b];
    assign staged_n[b]  = (staged_q[b] && !push_grant[b]) || acc[b];
    assign done_n[b]    = (done_q[b] && !acc[b]) || cmpl_mask[b];
  end

  txreq_pick #(.N(NBUF), .IW(IW)) u_pick (
    .req(staged_q), .grant(push_grant), .idx(push_idx)
  );

  assign q_push = |staged_q;

  txreq_queue #(.DEPTH(NBUF), .W(IW)) u_queue (
    .clk(clk), .rst(rst), .push(q_push), .din(push_idx), .pop(q_pop),
    .head(q_head), .empty(q_empty), .full(q_full)
  );

  txreq_engine #(.LATENCY(LATENCY), .IW(IW)) u_eng (
    .clk(clk), .rst(rst), .q_empty(q_empty), .q_head(q_head),
    .pop(q_pop), .cmpl(cmpl), .cur_idx(cur_idx)
  );

  assign irq_set[IRQ_FE] = cmpl;
  assign irq_set[IRQ_TC] = cmpl && tie_q[cur_idx];
  assign irq_clr         = wr_irq ? wr_data[IRQ_W-1:0] : '0;

  assign qput_nx = (qput_q == QW'(QDEPTH - 1)) ? '0 : qput_q + 1'b1;

  assign rx_push = cmpl && loop_q && (rx_fill_q != FW'(RX_DEPTH));
  assign rx_pop  = wr_ack && (rx_fill_q != '0);

  always_comb begin
    inflight = '0;
    for (int i = 0; i < NBUF; i++) inflight = inflight + PCW'(pend_q[i]);
    free_cnt = (32'(inflight) >= QDEPTH) ? 8'd0 : 8'(QDEPTH - 32'(inflight));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q       <= '0;
      staged_q     <= '0;
      done_q       <= '0;
      tie_q        <= '0;
      irq_q        <= '0;
      loop_q       <= 1'b0;
      qput_q       <= '0;
      qget_q       <= '0;
      rx_put_q     <= '0;
      rx_get_q     <= '0;
      rx_fill_q    <= '0;
      done_valid_q <= 1'b0;
      done_buf_q   <= '0;
    end else begin
      pend_q       <= pend_n;
      staged_q     <= staged_n;
      done_q       <= done_n;
      irq_q        <= (irq_q & ~irq_clr) | irq_set;
      done_valid_q <= cmpl;
      if (cmpl) done_buf_q <= cur_idx;
      if (wr_tie)  tie_q  <= wr_data[NBUF-1:0];
      if (wr_ctrl) loop_q <= wr_data[0];
      if (cmpl) begin
        qput_q <= qput_nx;
        qget_q <= qput_nx;
      end
      if (rx_push) rx_put_q <= (rx_put_q == RXW'(RX_DEPTH - 1)) ? '0 : rx_put_q + 1'b1;
      if (rx_pop)  rx_get_q <= (rx_get_q == RXW'(RX_DEPTH - 1)) ? '0 : rx_get_q + 1'b1;
      if (rx_push && !rx_pop)      rx_fill_q <= rx_fill_q + 1'b1;
      else if (rx_pop && !rx_push) rx_fill_q <= rx_fill_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      case (rd_addr)
        RA_PEND:   rd_q <= REG_W'(pend_q);
        RA_DONE:   rd_q <= REG_W'(done_q);
        RA_TIE:    rd_q <= REG_W'(tie_q);
        RA_QSTAT:  rd_q <= pack_status(8'(qput_q), 8'(qget_q), free_cnt);
        RA_IRQ:    rd_q <= REG_W'(irq_q);
        RA_RXSTAT: rd_q <= pack_status(8'(rx_put_q), 8'(rx_get_q), {1'b0, 7'(rx_fill_q)});
        RA_CTRL:   rd_q <= REG_W'(loop_q);
        default:   rd_q <= '0;
      endcase
    end
  end

  assign rd_data    = rd_q;
  assign done_valid = done_valid_q;
  assign done_buf   = done_buf_q;
endmodule

// File: rtl/txreq_checker.sv
module txreq_checker #(
  parameter int NBUF     = 4,
  parameter int QDEPTH   = 3,
  parameter int RX_DEPTH = 3,
  parameter int IW       = 2,
  parameter int QW       = 2,
  parameter int FW       = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [NBUF-1:0] pend,
  input logic [NBUF-1:0] done_reg,
  input logic [1:0]      irq,
  input logic [QW-1:0]   qput,
  input logic [QW-1:0]   qget,
  input logic [FW-1:0]   rx_fill,
  input logic            done_valid,
  input logic [IW-1:0]   done_buf,
  input logic            q_push,
  input logic            q_full
);
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
    !(q_push && q_full));

  p_pend_before_done_r2: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> ((($past(pend, 2)) >> done_buf) & NBUF'(1)) != '0);

  p_done_bit_r4: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> done_reg[done_buf]);

  p_fe_flag_r5: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> irq[0]);

  p_put_step_r7: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> (qput == (($past(qput) == QW'(QDEPTH - 1)) ? '0 : $past(qput) + 1'b1))
                   && (qget == qput));

  p_put_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !done_valid |-> $stable(qput));

  p_rx_bound_r10: assert property (@(posedge clk) disable iff (rst)
    rx_fill <= FW'(RX_DEPTH));

  p_reset_r11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pend == '0) && (done_reg == '0) && (irq == '0) && (qput == '0));
endmodule

bind can_txreq_tracker txreq_checker #(
  .NBUF(NBUF), .QDEPTH(QDEPTH), .RX_DEPTH(RX_DEPTH), .IW(IW), .QW(QW), .FW(FW)
) u_chk (
  .clk(clk), .rst(rst), .pend(pend_q), .done_reg(done_q), .irq(irq_q),
  .qput(qput_q), .qget(qget_q), .rx_fill(rx_fill_q), .done_valid(done_valid),
  .done_buf(done_buf), .q_push(q_push), .q_full(q_full)
);

// File: tb/sim_can_txreq_tracker.sv
module sim_can_txreq_tracker;
  import can_txreq_pkg::*;

  localparam int NBUF = 4;
  localparam int QD   = 3;
  localparam int LAT  = 4;
  localparam int RXD  = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        done_valid;
  logic [1:0]  done_buf;

  always #10 clk = ~clk;

  can_txreq_tracker #(.NBUF(NBUF), .QDEPTH(QD), .LATENCY(LAT), .RX_DEPTH(RXD)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .done_valid(done_valid), .done_buf(done_buf)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic finished = 1'b0;
  int log_n = 0;
  int log_buf [256];

  int m_qput = 0, m_rxput = 0, m_rxget = 0, m_rxfill = 0;
  logic m_loop = 1'b0;
  logic [3:0] m_done = '0;

  always @(negedge clk) begin
    if (!rst && done_valid) begin
      if (log_n < 256) log_buf[log_n] = int'(done_buf);
      log_n = log_n + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic wait_log(input int target);
    int guard = 0;
    while (log_n < target && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic model_sends(input int n);
    for (int i = 0; i < n; i++) begin
      m_qput = (m_qput + 1) % QD;
      if (m_loop && m_rxfill < RXD) begin
        m_rxfill++;
        m_rxput = (m_rxput + 1) % RXD;
      end
    end
  endtask

  task automatic model_ack();
    if (m_rxfill > 0) begin
      m_rxfill--;
      m_rxget = (m_rxget + 1) % RXD;
    end
  endtask

  function automatic logic [31:0] qstat_idle();
    return (32'(m_qput) << 16) | (32'(m_qput) << 8) | 32'(QD);
  endfunction

  function automatic logic [31:0] rxstat_exp();
    return (32'(m_rxput) << 16) | (32'(m_rxget) << 8) | 32'(m_rxfill);
  endfunction

  task automatic send(input logic [3:0] mask);
    int base, n, k;
    logic [31:0] v;
    base = log_n;
    n = $countones(mask);
    wreg(4'd0, 32'(mask));
    wait_log(base + n);
    check("R12 completion count", 32'(log_n), 32'(base + n));
    k = base;
    for (int b = 0; b < NBUF; b++) begin
      if (mask[b]) begin
        check("R3 ascending order / R12 index", 32'(log_buf[k]), 32'(b));
        k++;
      end
    end
    model_sends(n);
    m_done = m_done | mask;
    rreg(4'd1, v); check("R4 pending cleared", v, 32'h0);
    rreg(4'd2, v); check("R4 sent register", v, 32'(m_done));
    rreg(4'd4, v); check("R7 queue status", v, qstat_idle());
  endtask

  initial begin : main
    logic [31:0] v;
    int first, base;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    rreg(4'd1, v); check("R11 pending", v, 32'h0);
    rreg(4'd2, v); check("R11 sent", v, 32'h0);
    rreg(4'd5, v); check("R11 irq", v, 32'h0);
    rreg(4'd4, v); check("R11 queue status", v, 32'h0000_0003);
    rreg(4'd6, v); check("R11 rx status", v, 32'h0);

    wreg(4'd8, 32'h1);
    m_loop = 1'b1;

    // R2 exact completion latency
    base = log_n;
    first = 0;
    wreg(4'd0, 32'h1);
    for (int k = 1; k <= LAT + 5; k++) begin
      @(negedge clk);
      if (done_valid && first == 0) first = k;
    end
    check("R2 completion latency", 32'(first), 32'(LAT + 2));
    wait_log(base + 1);
    model_sends(1);
    m_done = 4'h1;
    rreg(4'd1, v); check("R4 pending cleared", v, 32'h0);
    rreg(4'd2, v); check("R4 sent bit", v, 32'h1);
    rreg(4'd5, v); check("R5 only queue-empty flag", v, 32'h1);
    rreg(4'd4, v); check("R7 status after one send", v, 32'h0001_0103);
    rreg(4'd6, v); check("R10 rx after loopback", v, 32'h0001_0001);
    wreg(4'd7, 32'h0);
    model_ack();
    rreg(4'd6, v); check("R10 rx after pop", v, 32'h0001_0100);

    // R6 write-one-to-clear
    rreg(4'd5, v);
    wreg(4'd5, v);
    rreg(4'd5, v); check("R6 flags cleared", v, 32'h0);

    // R5 transmit-complete flag enabled, second send
    wreg(4'd3, 32'h1);
    send(4'h1);
    rreg(4'd5, v); check("R5 both flags", v, 32'h3);
    rreg(4'd4, v); check("R7 status after two sends", v, 32'h0002_0203);

    // R1 pending visible, R8 free count
    base = log_n;
    wreg(4'd0, 32'h6);
    rreg(4'd1, v); check("R1 pending set", v, 32'h6);
    rreg(4'd4, v); check("R8 free with two in flight", v & 32'hFF, 32'h1);
    wait_log(base + 2);
    check("R3 order first", 32'(log_buf[base]), 32'h1);
    check("R3 order second", 32'(log_buf[base + 1]), 32'h2);
    model_sends(2);
    m_done = m_done | 4'h6;
    rreg(4'd6, v); check("R10 rx filled", v, rxstat_exp());

    base = log_n;
    wreg(4'd0, 32'hF);
    rreg(4'd4, v); check("R8 free saturates", v & 32'hFF, 32'h0);
    wait_log(base + 4);
    model_sends(4);
    m_done = 4'hF;
    rreg(4'd6, v); check("R10 full fifo drops", v, rxstat_exp());
    rreg(4'd4, v); check("R7 status after burst", v, qstat_idle());
    for (int i = 0; i < 3; i++) begin
      wreg(4'd7, 32'h0);
      model_ack();
    end
    rreg(4'd6, v); check("R10 rx drained", v, rxstat_exp());

    // R10 loopback off
    wreg(4'd8, 32'h0);
    m_loop = 1'b0;
    send(4'h2);
    rreg(4'd6, v); check("R10 no rx without loopback", v, rxstat_exp());

    // R3 order across separate writes
    base = log_n;
    wreg(4'd0, 32'h8);
    wreg(4'd0, 32'h2);
    wait_log(base + 2);
    check("R3 arrival order first", 32'(log_buf[base]), 32'h3);
    check("R3 arrival order second", 32'(log_buf[base + 1]), 32'h1);
    model_sends(2);

    // R1 duplicate request ignored
    base = log_n;
    wreg(4'd0, 32'h4);
    wreg(4'd0, 32'h4);
    wait_log(base + 1);
    repeat (3 * (LAT + 2)) @(negedge clk);
    check("R1 duplicate gives one completion", 32'(log_n), 32'(base + 1));
    model_sends(1);

    // R9 request coinciding with completion
    base = log_n;
    wreg(4'd0, 32'h1);
    repeat (LAT + 1) @(negedge clk);
    wreg(4'd0, 32'h1);
    check("R9 completion in that cycle", 32'(done_valid), 32'h1);
    rreg(4'd1, v); check("R9 pending kept", v, 32'h1);
    wait_log(base + 2);
    check("R9 second completion", 32'(log_n), 32'(base + 2));
    model_sends(2);
    rreg(4'd1, v); check("R9 pending finally clear", v, 32'h0);
    rreg(4'd4, v); check("R7 status after R9", v, qstat_idle());

    // R5 sweep over all masks with varying interrupt enables
    for (int mask = 1; mask < 16; mask++) begin
      logic [3:0] tie;
      tie = 4'((mask * 5 + 3) & 15);
      wreg(4'd3, 32'(tie));
      wreg(4'd5, 32'h3);
      send(4'(mask));
      rreg(4'd5, v);
      check("R5 flags vs enable", v, ((4'(mask) & tie) != 0) ? 32'h3 : 32'h1);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule